// File: doc/BRIEF.md
# UART Line Status Logic

This block maintains the read-only line status byte of a UART whose receive and transmit paths can work either through 16-entry FIFOs or through a single holding register. It does not move any data. The receive shifter reports each finished character with its parity, framing and break tags. The bus side reports removals from the receive buffer, loads into the transmit path and status accesses. The transmit shifter reports when it takes a character and whether its shift register is occupied. From these handshakes the block keeps the status byte and two interrupt requests.

The error tags travel in a small shadow queue that runs in step with the receive buffer, so a parity, framing or break flag appears only when its character becomes the oldest one held. A separate sticky summary bit tells software that errored characters are queued. Reading the status byte clears the receive error flags. A flag that is raised in the same cycle as the read survives that read. A status access with the write strobe high does nothing.

Top module: `uart_lsr`

## Requirements
- R1: After reset the status byte reads 0x60 while the shift register is idle, and both interrupt requests are low.
- R2: Bit 0 (data ready) is 1 while at least one received character is held, and returns to 0 once the last held character is removed.
- R3: A finished character that arrives while the receive buffer is full (16 entries in FIFO mode, 1 otherwise) is discarded and sets bit 1 (overrun).
- R4: Bits 2, 3 and 4 (parity, framing, break) take the tag of a character in the cycle it becomes the oldest held character. A tagged character queued behind an untagged one does not raise them.
- R5: Any status read clears bits 1 to 4. A flag raised in the same cycle as the read stays set.
- R6: Bit 7 is always 0 in single-register mode. In FIFO mode it sets when an errored character enters the buffer. A read clears it only if no errored character remains after that cycle.
- R7: Bit 5 (holding empty) is 0 while the transmit buffer holds any character. It is 1 when the transmitter has taken the last one.
- R8: Bit 6 (transmitter empty) is 1 exactly when bit 5 is 1 and the shift-busy input is low.
- R9: irq_rls is high exactly when ie_rls is high and any of bits 1 to 4 is set.
- R10: irq_thre is high exactly when ie_thre is high and bit 5 is set.
- R11: A status access with lsr_wr high changes no flag.
- R12: A load into a full transmit buffer (16 entries in FIFO mode, 1 otherwise) is ignored, so the buffer empties after exactly that many takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_mode | input | 1 | 1 selects FIFO mode, 0 selects single holding register |
| rx_done | input | 1 | Receive shifter finished a character |
| rx_par_err | input | 1 | Parity tag of the finished character |
| rx_frm_err | input | 1 | Framing tag of the finished character |
| rx_brk | input | 1 | Break tag of the finished character |
| rx_pop | input | 1 | Processor removes the oldest received character |
| lsr_sel | input | 1 | Status register access strobe |
| lsr_wr | input | 1 | Write qualifier of the status access |
| tx_load | input | 1 | Processor loads a transmit character |
| tx_take | input | 1 | Transmit shifter takes a character |
| tx_shift_busy | input | 1 | Transmit shift register holds a character |
| ie_rls | input | 1 | Receiver line status interrupt enable |
| ie_thre | input | 1 | Holding-empty interrupt enable |
| lsr | output | 8 | Status byte |
| irq_rls | output | 1 | Receiver line status interrupt request |
| irq_thre | output | 1 | Holding-empty interrupt request |

## Verification
Every flag register is updated at the clock edge that samples its stimulus, so bits 0 to 5 and bit 7 are due one edge after the input cycle. Bit 6 and both interrupt requests add no register after that: they follow the flags and the current shift-busy and enable inputs in the same cycle. The bench drives inputs at the falling edge and advances its reference model at the rising edge. It compares every output at the next falling edge, before it changes any input, so each comparison sees exactly one edge of effect.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;

   typedef struct packed {
      logic brk;
      logic frm;
      logic par;
   } rx_tag_t;

   localparam int unsigned LSR_DR    = 0;
   localparam int unsigned LSR_OE    = 1;
   localparam int unsigned LSR_PE    = 2;
   localparam int unsigned LSR_FE    = 3;
   localparam int unsigned LSR_BI    = 4;
   localparam int unsigned LSR_THRE  = 5;
   localparam int unsigned LSR_TEMT  = 6;
   localparam int unsigned LSR_RXERR = 7;

endpackage

// File: rtl/lsr_rx_tagq.sv
module lsr_rx_tagq
   import uart_lsr_pkg::*;
#(
   parameter int unsigned DEPTH = 16
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    fifo_mode,
   input  logic    push,
   input  rx_tag_t push_tag,
   input  logic    pop,
   output logic    full,
   output logic    not_empty,
   output logic    overrun,
   output rx_tag_t reveal,
   output logic    err_push,
   output logic    err_left
);
   localparam int unsigned PW = $clog2(DEPTH);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("lsr_rx_tagq: DEPTH must be a power of two of at least 2");
   end

   logic [CW-1:0] cnt_q, cnt_d, err_q, err_d, cap;
   logic [PW-1:0] wr_ptr_q, rd_ptr_q;
   rx_tag_t       mem_q [DEPTH];
   logic          push_ok, pop_ok, head_bad;

   assign cap       = fifo_mode ? CW'(DEPTH) : CW'(1);
   assign full      = cnt_q >= cap;
   assign not_empty = cnt_q != '0;
   assign pop_ok    = pop && not_empty;
   assign push_ok   = push && !full;
   assign overrun   = push && full;
   assign head_bad  = |mem_q[rd_ptr_q];
   assign err_push  = push_ok && (|push_tag);

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)                                mem_q[i] <= '0;
         else if (push_ok && wr_ptr_q == PW'(i))    mem_q[i] <= push_tag;
      end
   end

   // tag of the character that becomes the oldest one at this edge
   always_comb begin
      reveal = '0;
      if (pop_ok) begin
         if (cnt_q >= CW'(2))  reveal = mem_q[rd_ptr_q + PW'(1)];
         else if (push_ok)     reveal = push_tag;
      end else if (!not_empty && push_ok) begin
         reveal = push_tag;
      end
   end

   always_comb begin
      cnt_d = cnt_q;
      err_d = err_q;
      if (push_ok)             cnt_d = cnt_d + CW'(1);
      if (pop_ok)              cnt_d = cnt_d - CW'(1);
      if (err_push)            err_d = err_d + CW'(1);
      if (pop_ok && head_bad)  err_d = err_d - CW'(1);
   end
   assign err_left = err_d != '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         err_q    <= '0;
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
      end else begin
         cnt_q <= cnt_d;
         err_q <= err_d;
         if (push_ok) wr_ptr_q <= wr_ptr_q + PW'(1);
         if (pop_ok)  rd_ptr_q <= rd_ptr_q + PW'(1);
      end
   end

   AST_ERR_WITHIN_COUNT: assert property (@(posedge clk) disable iff (!rst_n) err_q <= cnt_q); // R6
   AST_RX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= CW'(DEPTH)); // R3
   AST_LAST_POP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && cnt_q == CW'(1)) |=> !not_empty); // R2

endmodule

// File: rtl/lsr_tx_track.sv
module lsr_tx_track #(
   parameter int unsigned DEPTH = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fifo_mode,
   input  logic load,
   input  logic take,
   input  logic shift_busy,
   output logic full,
   output logic thre,
   output logic temt
);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   if (DEPTH < 1) begin : g_bad_depth
      $error("lsr_tx_track: DEPTH must be at least 1");
   end

   logic [CW-1:0] cnt_q, cap;
   logic          load_ok, take_ok;

   assign cap     = fifo_mode ? CW'(DEPTH) : CW'(1);
   assign full    = cnt_q >= cap;
   assign load_ok = load && !full;
   assign take_ok = take && (cnt_q != '0);
   assign thre    = cnt_q == '0;
   assign temt    = thre && !shift_busy;

   always_ff @(posedge clk) begin
      if (!rst_n)                     cnt_q <= '0;
      else if (load_ok && !take_ok)   cnt_q <= cnt_q + CW'(1);
      else if (take_ok && !load_ok)   cnt_q <= cnt_q - CW'(1);
   end

   AST_TX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= CW'(DEPTH)); // R12
   AST_LOAD_CLEARS_THRE: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !full && !take) |=> !thre); // R7
   AST_FULL_LOAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (load && full && !take) |=> $stable(cnt_q)); // R12

endmodule

// File: rtl/uart_lsr.sv
module uart_lsr
   import uart_lsr_pkg::*;
#(
   parameter int unsigned RX_DEPTH = 16,
   parameter int unsigned TX_DEPTH = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fifo_mode,
   input  logic       rx_done,
   input  logic       rx_par_err,
   input  logic       rx_frm_err,
   input  logic       rx_brk,
   input  logic       rx_pop,
   input  logic       lsr_sel,
   input  logic       lsr_wr,
   input  logic       tx_load,
   input  logic       tx_take,
   input  logic       tx_shift_busy,
   input  logic       ie_rls,
   input  logic       ie_thre,
   output logic [7:0] lsr,
   output logic       irq_rls,
   output logic       irq_thre
);
   rx_tag_t in_tag, reveal;
   logic    rx_full, rx_avail, rx_ovr, err_push, err_left;
   logic    tx_full, thre, temt;
   logic    rd;
   logic    oe_q, pe_q, fe_q, bi_q, rxerr_q;

   assign in_tag = '{brk: rx_brk, frm: rx_frm_err, par: rx_par_err};
   assign rd     = lsr_sel && !lsr_wr;

   lsr_rx_tagq #(.DEPTH(RX_DEPTH)) u_rxq (
      .clk       (clk),
      .rst_n     (rst_n),
      .fifo_mode (fifo_mode),
      .push      (rx_done),
      .push_tag  (in_tag),
      .pop       (rx_pop),
      .full      (rx_full),
      .not_empty (rx_avail),
      .overrun   (rx_ovr),
      .reveal    (reveal),
      .err_push  (err_push),
      .err_left  (err_left)
   );

   lsr_tx_track #(.DEPTH(TX_DEPTH)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .fifo_mode  (fifo_mode),
      .load       (tx_load),
      .take       (tx_take),
      .shift_busy (tx_shift_busy),
      .full       (tx_full),
      .thre       (thre),
      .temt       (temt)
   );

   // a new event wins over the clear of a read in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         oe_q    <= 1'b0;
         pe_q    <= 1'b0;
         fe_q    <= 1'b0;
         bi_q    <= 1'b0;
         rxerr_q <= 1'b0;
      end else begin
         oe_q    <= rx_ovr     | (oe_q & ~rd);
         pe_q    <= reveal.par | (pe_q & ~rd);
         fe_q    <= reveal.frm | (fe_q & ~rd);
         bi_q    <= reveal.brk | (bi_q & ~rd);
         rxerr_q <= err_push   | (rxerr_q & ~(rd & ~err_left));
      end
   end

   always_comb begin
      lsr            = '0;
      lsr[LSR_DR]    = rx_avail;
      lsr[LSR_OE]    = oe_q;
      lsr[LSR_PE]    = pe_q;
      lsr[LSR_FE]    = fe_q;
      lsr[LSR_BI]    = bi_q;
      lsr[LSR_THRE]  = thre;
      lsr[LSR_TEMT]  = temt;
      lsr[LSR_RXERR] = fifo_mode & rxerr_q;
   end

   assign irq_rls  = ie_rls  & (oe_q | pe_q | fe_q | bi_q);
   assign irq_thre = ie_thre & thre;

   AST_OVERRUN_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && rx_full) |=> lsr[LSR_OE]); // R3
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !rx_done && reveal == '0) |=> (lsr[4:1] == 4'b0000)); // R5
   AST_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_sel && lsr_wr && !rx_done && !rx_pop) |=> $stable({oe_q, pe_q, fe_q, bi_q, rxerr_q})); // R11
   AST_RXERR_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_mode && err_push) |=> (lsr[LSR_RXERR] || !fifo_mode)); // R6
   AST_TX_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_full |-> !lsr[LSR_THRE]); // R7

endmodule

// File: tb/sim_uart_lsr.sv
`timescale 1ns/1ps
module sim_uart_lsr;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fifo_mode, rx_done, rx_pop, lsr_sel, lsr_wr;
   logic       tx_load, tx_take, tx_shift_busy, ie_rls, ie_thre;
   logic [2:0] tag;
   logic [7:0] lsr;
   logic       irq_rls, irq_thre;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   // reference state, built from the requirements
   logic [2:0] mq[$];
   bit m_oe, m_pe, m_fe, m_bi, m_ferr;
   int m_txc;

   always #4 clk = ~clk;

   uart_lsr u0 (
      .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
      .rx_done(rx_done), .rx_par_err(tag[0]), .rx_frm_err(tag[1]), .rx_brk(tag[2]),
      .rx_pop(rx_pop), .lsr_sel(lsr_sel), .lsr_wr(lsr_wr),
      .tx_load(tx_load), .tx_take(tx_take), .tx_shift_busy(tx_shift_busy),
      .ie_rls(ie_rls), .ie_thre(ie_thre),
      .lsr(lsr), .irq_rls(irq_rls), .irq_thre(irq_thre)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic idle();
      rx_done = 0; rx_pop = 0; lsr_sel = 0; lsr_wr = 0;
      tx_load = 0; tx_take = 0; tag = 3'b000;
   endtask

   task automatic model_edge();
      bit rd, pop_ok, push_ok, full, ov;
      int cap, sz, errs, tcap;
      logic [2:0] rev;
      rd = lsr_sel && !lsr_wr;
      cap = fifo_mode ? 16 : 1;
      sz = mq.size();
      pop_ok = rx_pop && sz > 0;
      full = sz >= cap;
      push_ok = rx_done && !full;
      ov = rx_done && full;
      rev = 3'b000;
      if (pop_ok) begin
         if (sz >= 2) rev = mq[1];
         else if (push_ok) rev = tag;
      end else if (sz == 0 && push_ok) rev = tag;
      if (pop_ok) void'(mq.pop_front());
      if (push_ok) mq.push_back(tag);
      errs = 0;
      foreach (mq[i]) if (mq[i] != 3'b000) errs++;
      m_oe = ov     | (m_oe && !rd);
      m_pe = rev[0] | (m_pe && !rd);
      m_fe = rev[1] | (m_fe && !rd);
      m_bi = rev[2] | (m_bi && !rd);
      m_ferr = (push_ok && tag != 3'b000) | (m_ferr && !(rd && errs == 0));
      tcap = fifo_mode ? 16 : 1;
      if (tx_load && m_txc < tcap && !(tx_take && m_txc > 0)) m_txc++;
      else if (tx_take && m_txc > 0 && !(tx_load && m_txc < tcap)) m_txc--;
   endtask

   task automatic compare_all();
      bit thre;
      thre = (m_txc == 0);
      chk("R2 data ready", lsr[0], mq.size() != 0);
      chk("R3 overrun", lsr[1], m_oe);
      chk("R4 parity", lsr[2], m_pe);
      chk("R4 framing", lsr[3], m_fe);
      chk("R4 break", lsr[4], m_bi);
      chk("R7 holding empty", lsr[5], thre);
      chk("R8 transmitter empty", lsr[6], thre && !tx_shift_busy);
      chk("R6 fifo error", lsr[7], fifo_mode && m_ferr);
      chk("R9 irq_rls", irq_rls, ie_rls && (m_oe || m_pe || m_fe || m_bi));
      chk("R10 irq_thre", irq_thre, ie_thre && thre);
   endtask

   // one clock: edge applies inputs to design and model, then compare
   task automatic step();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare_all();
      idle();
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: run did not finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h5eed_1a2b));
      idle();
      fifo_mode = 1; tx_shift_busy = 0; ie_rls = 0; ie_thre = 0;
      m_oe = 0; m_pe = 0; m_fe = 0; m_bi = 0; m_ferr = 0; m_txc = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      // R1: reset value
      chk("R1 reset byte", lsr, 8'h60);
      chk("R1 irq_rls", irq_rls, 0);
      chk("R1 irq_thre", irq_thre, 0);

      // R4: parity-tagged character behind a clean one stays hidden
      rx_done = 1; step();
      rx_done = 1; tag = 3'b001; step();
      chk("R4 hidden behind clean head", lsr[2], 0);
      chk("R6 errored char queued", lsr[7], 1);
      rx_pop = 1; step();
      chk("R4 revealed at head", lsr[2], 1);
      // R6: read with errored char still held keeps bit 7
      lsr_sel = 1; step();
      chk("R5 parity cleared by read", lsr[2], 0);
      chk("R6 kept while errored char held", lsr[7], 1);
      rx_pop = 1; step();
      lsr_sel = 1; step();
      chk("R6 cleared once none remain", lsr[7], 0);

      // R3 and R5: fill, overflow in the same cycle as a read
      repeat (16) begin rx_done = 1; step(); end
      rx_done = 1; lsr_sel = 1; step();
      chk("R5 overrun raised during read survives", lsr[1], 1);
      // R11: write-qualified access leaves flags alone
      lsr_sel = 1; lsr_wr = 1; step();
      chk("R11 write leaves overrun", lsr[1], 1);
      ie_rls = 1; step();
      lsr_sel = 1; step();
      chk("R5 read clears overrun", lsr[1], 0);
      repeat (16) begin rx_pop = 1; step(); end
      chk("R2 empty after drain", lsr[0], 0);

      // R12: extra load into full transmit buffer is dropped
      ie_thre = 1;
      repeat (17) begin tx_load = 1; step(); end
      repeat (15) begin tx_take = 1; step(); end
      chk("R12 one left after 15 takes", lsr[5], 0);
      tx_take = 1; step();
      chk("R12 empty after 16 takes", lsr[5], 1);
      tx_shift_busy = 1; step();
      chk("R8 busy shifter", lsr[6], 0);
      tx_shift_busy = 0;

      // single-register mode: one slot, no fifo error bit
      fifo_mode = 0; step();
      rx_done = 1; tag = 3'b010; step();
      chk("R4 framing at once in single mode", lsr[3], 1);
      chk("R6 zero in single mode", lsr[7], 0);
      rx_done = 1; step();
      chk("R3 overrun with one slot", lsr[1], 1);
      rx_pop = 1; lsr_sel = 1; step();

      // constrained random phase
      for (int cyc = 0; cyc < 3000; cyc++) begin
         if (cyc % 500 == 0) fifo_mode = $urandom_range(0, 3) != 0;
         if ($urandom_range(0, 31) == 0) ie_rls = $urandom_range(0, 1);
         if ($urandom_range(0, 31) == 0) ie_thre = $urandom_range(0, 1);
         rx_done = $urandom_range(0, 99) < 30;
         tag[0] = $urandom_range(0, 99) < 15;
         tag[1] = $urandom_range(0, 99) < 15;
         tag[2] = $urandom_range(0, 99) < 10;
         rx_pop = $urandom_range(0, 99) < 25;
         lsr_sel = $urandom_range(0, 99) < 15;
         lsr_wr = $urandom_range(0, 99) < 30;
         tx_load = $urandom_range(0, 99) < 30;
         tx_take = $urandom_range(0, 99) < 30;
         tx_shift_busy = $urandom_range(0, 99) < 40;
         step();
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule